// File: doc/BRIEF.md
# USB Transmit Endpoint FIFO Controller

This block owns the byte FIFO and the command register of a single USB transmit endpoint, and decides when packet bytes are passed to a downstream MAC. Firmware loads payload bytes and sets command bits through a small register port. When an IN token arrives and the endpoint is armed, the controller streams the FIFO contents as data beats over a byte-wide valid/ready interface. It then sends one closing marker beat that tells the MAC to append CRC and end the packet. The marker beat can instead tell the MAC to abort with a forced stuff error.

The controller tracks the data PID the MAC should use and detects underrun. It raises a programmable low-level warning and counts write overflow. It also supports two recovery paths: a deferred flush, and a refill that rewinds the read pointer to where it stood when the packet was sealed, so the packet can be sent again after a missing ACK. On isochronous endpoints, a queued packet is tied to the parity of the frame number. A packet that goes unclaimed while its frame was current is discarded at the next start-of-frame.

Top module: `usb_tx_ep_ctrl`

## Requirements
- R1: After reset the command register reads 0x00, the status register reads 0x00 and `tx_valid` is low.
- R2: Register map: address 0 writes a FIFO byte, address 1 is the command register (bit 0 enable, bit 1 sealed/LAST, bit 2 toggle, bit 3 flush, bit 4 refill, bits 6:5 warning code, bit 7 ignore frame parity), address 2 is status (bit 0 done, bit 1 underrun, bit 2 overflow, bit 3 live warning). A status read returns the bits and clears bits 0 to 2.
- R3: A packet starts only on `in_tok` while enable is set. Bytes leave in write order as beats with `tx_eop`=0, followed by one beat with `tx_eop`=1 and `tx_data`=0. When that beat is accepted, hardware clears enable and LAST and sets done.
- R4: `tx_pid1` equals toggle on a non-isochronous endpoint and is 0 on an isochronous one. Hardware never changes toggle.
- R5: Sending with LAST set and an empty FIFO yields only the closing beat, with `tx_abort`=0.
- R6: If the FIFO empties during a packet while LAST is clear, the closing beat carries `tx_abort`=1 and the underrun status bit is set.
- R7: A `stall_evt` while idle and enabled clears enable and sends nothing.
- R8: Writing 1 to flush empties the FIFO and then self-clears. A flush written during a packet takes effect only after that packet has ended.
- R9: Setting LAST saves the read pointer. Writing 1 to refill reloads it (after any active packet) and self-clears, so the same bytes are sent again.
- R10: On an isochronous endpoint with bit 7 clear, sending is allowed only while `frame_lsb` equals toggle. If that match held and no packet started, the next `sof_evt` flushes the FIFO, clears enable and LAST, and sets done. Bit 7 set removes the parity gate.
- R11: Warning is high only while enable is set and code is non-zero, and the byte count is at or below `WARN_BASE << (code-1)`.
- R12: A byte write to a full FIFO is dropped and sets the overflow status bit.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_eop` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on address 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address |
| iso_mode | input | 1 | Endpoint is isochronous |
| frame_lsb | input | 1 | Bit 0 of the current frame number |
| in_tok | input | 1 | IN token addressed to this endpoint |
| sof_evt | input | 1 | Start-of-frame strobe |
| stall_evt | input | 1 | A STALL was returned to the IN token |
| tx_valid | output | 1 | Beat valid toward the MAC |
| tx_ready | input | 1 | MAC accepts the beat |
| tx_data | output | 8 | Payload byte (0 on the closing beat) |
| tx_eop | output | 1 | Closing beat of a packet |
| tx_abort | output | 1 | Closing beat must force a stuff error |
| tx_pid1 | output | 1 | 1 selects DATA1, 0 selects DATA0 |
| tx_warn | output | 1 | Low-level warning |

## Verification
The bench builds the block with an 8-byte FIFO and a warning base of 1, so the warning limits become 1, 2 and 4 bytes. With these values, the full-FIFO overflow drop and every warning code can be reached with a few register writes. The MAC side is throttled with a repeating ready pattern, which keeps a flush written mid-packet pending long enough to show that it is deferred. A refill issued after that deferred flush must yield an empty packet, and this separates a flush that really cleared the saved pointer from one that did not.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_CMD  = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;

   // command register, bit 0 first from the right
   typedef struct packed {
      logic       ign_iso;
      logic [1:0] wlim;
      logic       refill;
      logic       flush;
      logic       toggle;
      logic       last;
      logic       tx_en;
   } txcmd_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_SEND = 2'd1,
      SQ_FIN  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/usbtx_fifo.sv
module usbtx_fifo #(
   parameter int DEPTH = 32,
   parameter int DW    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [DW-1:0]              wdata,
   input  logic                       pop,
   input  logic                       clear,
   input  logic                       save,
   input  logic                       reload,
   output logic [DW-1:0]              head,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("usbtx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [PW-1:0] wr_q, rd_q, save_q;
   logic [DW-1:0] slots [DEPTH];
   logic          push_ok;

   assign push_ok = push && !full;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (push_ok && wr_q[AW-1:0] == AW'(i)) q <= wdata;
      end
      assign slots[i] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         wr_q   <= '0;
         rd_q   <= '0;
         save_q <= '0;
      end else begin
         if (push_ok) wr_q <= wr_q + 1'b1;
         if (reload)   rd_q <= save_q;
         else if (pop) rd_q <= rd_q + 1'b1;
         if (save)     save_q <= rd_q;
      end
   end

   assign count = wr_q - rd_q;
   assign full  = (count == PW'(DEPTH));
   assign empty = (count == '0);
   assign head  = slots[rd_q[AW-1:0]];

endmodule

// File: rtl/usbtx_warn.sv
module usbtx_warn #(
   parameter int DEPTH     = 32,
   parameter int WARN_BASE = 4,
   parameter bit WARN_REG  = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [1:0]             code,
   input  logic [$clog2(DEPTH):0] count,
   output logic                   warn
);
   localparam int PW = $clog2(DEPTH) + 1;

   if (WARN_BASE < 1 || (WARN_BASE << 2) > DEPTH) begin : g_bad_base
      $error("usbtx_warn: WARN_BASE*4 must fit within DEPTH");
   end

   logic [PW-1:0] lim;
   logic          raw;

   always_comb begin
      lim = '0;
      if (code != 2'd0) lim = PW'(WARN_BASE) << (code - 2'd1);
   end

   assign raw = en && (code != 2'd0) && (count <= lim);

   if (WARN_REG) begin : g_reg
      logic warn_q;
      always_ff @(posedge clk) begin
         if (!rst_n) warn_q <= 1'b0;
         else        warn_q <= raw;
      end
      assign warn = warn_q;
   end else begin : g_comb
      assign warn = raw;
   end

endmodule

// File: rtl/usbtx_seq.sv
module usbtx_seq
   import usbtx_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  txcmd_t        cmd,
   input  logic          iso_mode,
   input  logic          frame_lsb,
   input  logic          in_tok,
   input  logic          sof_evt,
   input  logic          stall_evt,
   input  logic          fifo_empty,
   input  logic [DW-1:0] fifo_head,
   output logic          fifo_pop,
   output logic          tx_valid,
   input  logic          tx_ready,
   output logic [DW-1:0] tx_data,
   output logic          tx_eop,
   output logic          tx_abort,
   output logic          pkt_done,
   output logic          stall_clr,
   output logic          iso_flush,
   output logic          flush_ack,
   output logic          refill_ack,
   output logic          urun_evt
);
   seq_state_e state_q, state_d;
   logic       abort_q, armed_q, armed_d;
   logic       idle, gate_ok, parity_ok, start;

   assign idle      = (state_q == SQ_IDLE);
   assign parity_ok = (frame_lsb == cmd.toggle);
   assign gate_ok   = !iso_mode || cmd.ign_iso || parity_ok;

   assign stall_clr  = idle && cmd.tx_en && stall_evt;
   assign start      = idle && cmd.tx_en && in_tok && !stall_evt && gate_ok;
   assign iso_flush  = idle && cmd.tx_en && sof_evt && armed_q && !stall_evt && !start;
   assign flush_ack  = idle && cmd.flush && !start;
   assign refill_ack = idle && cmd.refill && !start && !cmd.flush && !iso_flush;

   assign armed_d = idle && !start && !iso_flush && iso_mode && !cmd.ign_iso &&
                    cmd.tx_en && !stall_evt && (armed_q || parity_ok);

   assign urun_evt = (state_q == SQ_SEND) && fifo_empty && !cmd.last;

   always_comb begin
      state_d  = state_q;
      tx_valid = 1'b0;
      tx_data  = '0;
      tx_eop   = 1'b0;
      tx_abort = 1'b0;
      fifo_pop = 1'b0;
      pkt_done = 1'b0;
      unique case (state_q)
         SQ_IDLE: if (start) state_d = SQ_SEND;
         SQ_SEND: begin
            if (fifo_empty) begin
               state_d = SQ_FIN;
            end else begin
               tx_valid = 1'b1;
               tx_data  = fifo_head;
               fifo_pop = tx_ready;
            end
         end
         SQ_FIN: begin
            tx_valid = 1'b1;
            tx_eop   = 1'b1;
            tx_abort = abort_q;
            if (tx_ready) begin
               pkt_done = 1'b1;
               state_d  = SQ_IDLE;
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         abort_q <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         state_q <= state_d;
         armed_q <= armed_d;
         if (state_q == SQ_SEND && fifo_empty) abort_q <= !cmd.last;
      end
   end

endmodule

// File: rtl/usb_tx_ep_ctrl.sv
module usb_tx_ep_ctrl
   import usbtx_pkg::*;
#(
   parameter int DEPTH     = 32,
   parameter int WARN_BASE = 4,
   parameter bit WARN_REG  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       iso_mode,
   input  logic       frame_lsb,
   input  logic       in_tok,
   input  logic       sof_evt,
   input  logic       stall_evt,
   output logic       tx_valid,
   input  logic       tx_ready,
   output logic [7:0] tx_data,
   output logic       tx_eop,
   output logic       tx_abort,
   output logic       tx_pid1,
   output logic       tx_warn
);
   localparam int DW = 8;
   localparam int PW = $clog2(DEPTH) + 1;

   txcmd_t        cmd_q, cmd_d, cmd_w;
   logic          done_q, urun_q, ovf_q;
   logic          wr_cmd, wr_data, rd_stat, save;
   logic          fifo_pop, fifo_full, fifo_empty;
   logic [DW-1:0] fifo_head;
   logic [PW-1:0] fifo_count;
   logic          pkt_done, stall_clr, iso_flush, flush_ack, refill_ack, urun_evt;

   assign cmd_w   = txcmd_t'(reg_wdata);
   assign wr_cmd  = reg_wr && (reg_addr == ADDR_CMD);
   assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
   assign rd_stat = reg_rd && (reg_addr == ADDR_STAT);
   assign save    = wr_cmd && cmd_w.last && !cmd_q.last;

   usbtx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (wr_data),
      .wdata  (reg_wdata),
      .pop    (fifo_pop),
      .clear  (flush_ack || iso_flush),
      .save   (save),
      .reload (refill_ack),
      .head   (fifo_head),
      .count  (fifo_count),
      .full   (fifo_full),
      .empty  (fifo_empty)
   );

   usbtx_seq #(.DW(DW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd_q),
      .iso_mode   (iso_mode),
      .frame_lsb  (frame_lsb),
      .in_tok     (in_tok),
      .sof_evt    (sof_evt),
      .stall_evt  (stall_evt),
      .fifo_empty (fifo_empty),
      .fifo_head  (fifo_head),
      .fifo_pop   (fifo_pop),
      .tx_valid   (tx_valid),
      .tx_ready   (tx_ready),
      .tx_data    (tx_data),
      .tx_eop     (tx_eop),
      .tx_abort   (tx_abort),
      .pkt_done   (pkt_done),
      .stall_clr  (stall_clr),
      .iso_flush  (iso_flush),
      .flush_ack  (flush_ack),
      .refill_ack (refill_ack),
      .urun_evt   (urun_evt)
   );

   usbtx_warn #(.DEPTH(DEPTH), .WARN_BASE(WARN_BASE), .WARN_REG(WARN_REG)) u_warn (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cmd_q.tx_en),
      .code  (cmd_q.wlim),
      .count (fifo_count),
      .warn  (tx_warn)
   );

   // hardware updates first, a firmware write then overrides the plain fields
   always_comb begin
      cmd_d = cmd_q;
      if (pkt_done || iso_flush) begin
         cmd_d.tx_en = 1'b0;
         cmd_d.last  = 1'b0;
      end
      if (stall_clr)  cmd_d.tx_en  = 1'b0;
      if (flush_ack)  cmd_d.flush  = 1'b0;
      if (refill_ack) cmd_d.refill = 1'b0;
      if (wr_cmd) begin
         cmd_d.tx_en   = cmd_w.tx_en;
         cmd_d.last    = cmd_w.last;
         cmd_d.toggle  = cmd_w.toggle;
         cmd_d.wlim    = cmd_w.wlim;
         cmd_d.ign_iso = cmd_w.ign_iso;
         cmd_d.flush   = cmd_d.flush  | cmd_w.flush;
         cmd_d.refill  = cmd_d.refill | cmd_w.refill;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         done_q <= 1'b0;
         urun_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         cmd_q  <= cmd_d;
         done_q <= (done_q && !rd_stat) || pkt_done || iso_flush;
         urun_q <= (urun_q && !rd_stat) || urun_evt;
         ovf_q  <= (ovf_q  && !rd_stat) || (wr_data && fifo_full);
      end
   end

   always_comb begin
      unique case (reg_addr)
         ADDR_CMD:  reg_rdata = cmd_q;
         ADDR_STAT: reg_rdata = {4'b0, tx_warn, ovf_q, urun_q, done_q};
         default:   reg_rdata = '0;
      endcase
   end

   assign tx_pid1 = !iso_mode && cmd_q.toggle;

endmodule

// File: rtl/usbtx_checker.sv
module usbtx_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [1:0] reg_addr,
   input logic       iso_mode,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       tx_eop,
   input logic       tx_abort,
   input logic       tx_pid1,
   input logic       tx_warn,
   input logic [7:0] cmd_bits,
   input logic       ovf_bit,
   input logic       fifo_full
);
   logic wr_cmd, wr_dat;
   assign wr_cmd = reg_wr && (reg_addr == 2'd1);
   assign wr_dat = reg_wr && (reg_addr == 2'd0);

   assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_eop));

   assert_iso_data0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      iso_mode && tx_valid |-> !tx_pid1);

   assert_toggle_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cmd |=> $stable(cmd_bits[2]));

   assert_abort_on_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |-> tx_valid && tx_eop);

   assert_close_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && tx_eop && !wr_cmd |=> !cmd_bits[0] && !cmd_bits[1]);

   assert_warn_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_warn |-> cmd_bits[0] || $past(cmd_bits[0]));

   assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dat && fifo_full |=> ovf_bit);

endmodule

bind usb_tx_ep_ctrl usbtx_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .iso_mode  (iso_mode),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_data   (tx_data),
   .tx_eop    (tx_eop),
   .tx_abort  (tx_abort),
   .tx_pid1   (tx_pid1),
   .tx_warn   (tx_warn),
   .cmd_bits  (cmd_q),
   .ovf_bit   (ovf_q),
   .fifo_full (fifo_full)
);

// File: tb/test_usb_tx_ep_ctrl.sv
module test_usb_tx_ep_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       iso_mode = 1'b0, frame_lsb = 1'b0;
   logic       in_tok = 1'b0, sof_evt = 1'b0, stall_evt = 1'b0;
   logic       tx_valid, tx_ready = 1'b1;
   logic [7:0] tx_data;
   logic       tx_eop, tx_abort, tx_pid1, tx_warn;

   int checks = 0, fails = 0;
   bit throttle = 1'b0;
   bit finished = 1'b0;

   typedef struct packed {
      logic       eop;
      logic       abort;
      logic       pid1;
      logic [7:0] d;
   } beat_t;
   beat_t exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   usb_tx_ep_ctrl #(.DEPTH(8), .WARN_BASE(1)) i_usb_tx_ep_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .iso_mode(iso_mode), .frame_lsb(frame_lsb), .in_tok(in_tok),
      .sof_evt(sof_evt), .stall_evt(stall_evt), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_data(tx_data), .tx_eop(tx_eop),
      .tx_abort(tx_abort), .tx_pid1(tx_pid1), .tx_warn(tx_warn)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_beat(input logic eop, input logic abort, input logic pid1,
                              input logic [7:0] d, input string tag);
      beat_t b;
      b.eop = eop; b.abort = abort; b.pid1 = pid1; b.d = d;
      exp_q.push_back(b);
      tag_q.push_back(tag);
   endtask

   task automatic expect_bytes(input int n, input logic [7:0] base, input logic pid1,
                               input string tag);
      for (int i = 0; i < n; i++) expect_beat(1'b0, 1'b0, pid1, base + 8'(i), tag);
   endtask

   // scoreboard monitor: drives ready, then samples the beat taken at the next edge
   initial begin
      beat_t e, got;
      string t;
      int cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         tx_ready = throttle ? (cyc % 3 != 2) : 1'b1;
         #1;
         if (rst_n && tx_valid && tx_ready) begin
            got = {tx_eop, tx_abort, tx_pid1, tx_data};
            checks++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R3 unexpected beat actual=%0h expected=none", got);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (got !== e) begin
                  fails++;
                  $display("FAIL %s beat actual=%0h expected=%0h", t, got, e);
               end
            end
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic fill(input int n, input logic [7:0] base);
      for (int i = 0; i < n; i++) wr(2'd0, base + 8'(i));
   endtask

   task automatic pulse_in();
      @(negedge clk); in_tok = 1'b1;
      @(negedge clk); in_tok = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd1, v); chk("R1 cmd after reset", v, 8'h00);
      rd(2'd2, v); chk("R1 status after reset", v, 8'h00);
      chk("R1 tx_valid after reset", tx_valid, 1'b0);

      // R3 R4 basic DATA1 packet, no start before IN
      fill(3, 8'hA0);
      wr(2'd1, 8'h07);
      repeat (5) @(negedge clk);
      chk("R3 no beat before IN", tx_valid, 1'b0);
      expect_bytes(3, 8'hA0, 1'b1, "R3 R4 data1 packet");
      expect_beat(1'b1, 1'b0, 1'b1, 8'h00, "R3 close beat");
      pulse_in(); drain();
      rd(2'd1, v); chk("R3 R4 cmd after packet", v, 8'h04);
      rd(2'd2, v); chk("R3 done set", v, 8'h01);
      rd(2'd2, v); chk("R2 status read clears", v, 8'h00);

      // R9 refill replays the sealed bytes
      wr(2'd1, 8'h14);
      repeat (3) @(negedge clk);
      rd(2'd1, v); chk("R9 refill self-clears", v, 8'h04);
      wr(2'd1, 8'h07);
      expect_bytes(3, 8'hA0, 1'b1, "R9 replayed bytes");
      expect_beat(1'b1, 1'b0, 1'b1, 8'h00, "R9 replay close");
      pulse_in(); drain();
      rd(2'd2, v); chk("R9 done after replay", v, 8'h01);

      // R8 R5 flush then zero-length packet
      wr(2'd1, 8'h08);
      repeat (3) @(negedge clk);
      rd(2'd1, v); chk("R8 flush self-clears", v, 8'h00);
      wr(2'd1, 8'h03);
      expect_beat(1'b1, 1'b0, 1'b0, 8'h00, "R5 R8 zero-length after flush");
      pulse_in(); drain();
      rd(2'd2, v); chk("R5 done", v, 8'h01);

      // R6 underrun without LAST
      fill(2, 8'hB0);
      wr(2'd1, 8'h01);
      expect_bytes(2, 8'hB0, 1'b0, "R6 bytes before underrun");
      expect_beat(1'b1, 1'b1, 1'b0, 8'h00, "R6 aborted close");
      pulse_in(); drain();
      rd(2'd2, v); chk("R6 underrun and done", v, 8'h03);
      rd(2'd1, v); chk("R6 enable cleared", v, 8'h00);

      // R7 stall clears enable, nothing sent
      wr(2'd1, 8'h03);
      @(negedge clk); stall_evt = 1'b1;
      @(negedge clk); stall_evt = 1'b0;
      repeat (2) @(negedge clk);
      rd(2'd1, v); chk("R7 stall clears enable", v, 8'h02);
      pulse_in();
      repeat (5) @(negedge clk);
      rd(2'd2, v); chk("R7 no packet after stall", v, 8'h00);
      wr(2'd1, 8'h08);
      repeat (3) @(negedge clk);

      // R8 flush written mid-packet is deferred
      throttle = 1'b1;
      fill(4, 8'hC0);
      wr(2'd1, 8'h03);
      expect_bytes(4, 8'hC0, 1'b0, "R8 packet not cut by flush");
      expect_beat(1'b1, 1'b0, 1'b0, 8'h00, "R8 close after deferred flush");
      pulse_in();
      wr(2'd1, 8'h0B);
      drain();
      rd(2'd1, v); chk("R8 deferred flush applied", v, 8'h00);
      wr(2'd1, 8'h10);
      repeat (3) @(negedge clk);
      wr(2'd1, 8'h03);
      expect_beat(1'b1, 1'b0, 1'b0, 8'h00, "R8 R9 refill after flush is empty");
      pulse_in(); drain();
      throttle = 1'b0;
      rd(2'd2, v); chk("R8 done", v, 8'h01);

      // R11 warning limits (base 1: codes map to 1, 2, 4)
      fill(3, 8'hE0);
      wr(2'd1, 8'h60);
      rd(2'd2, v); chk("R11 no warn while disabled", v, 8'h00);
      wr(2'd1, 8'h61);
      rd(2'd2, v); chk("R11 warn 3 <= 4", v, 8'h08);
      wr(2'd1, 8'h41);
      rd(2'd2, v); chk("R11 no warn 3 > 2", v, 8'h00);
      wr(2'd1, 8'h01);
      rd(2'd2, v); chk("R11 code 0 disabled", v, 8'h00);
      wr(2'd1, 8'h08);
      repeat (3) @(negedge clk);

      // R12 overflow drop
      fill(9, 8'hF0);
      rd(2'd2, v); chk("R12 overflow flag", v, 8'h04);
      wr(2'd1, 8'h03);
      expect_bytes(8, 8'hF0, 1'b0, "R12 only first 8 bytes kept");
      expect_beat(1'b1, 1'b0, 1'b0, 8'h00, "R12 close");
      pulse_in(); drain();
      rd(2'd2, v); chk("R12 done, overflow cleared by read", v, 8'h01);

      // R10 R4 isochronous parity gate
      iso_mode = 1'b1; frame_lsb = 1'b1;
      fill(2, 8'h50);
      wr(2'd1, 8'h03);
      pulse_in();
      repeat (5) @(negedge clk);
      rd(2'd1, v); chk("R10 blocked on parity mismatch", v, 8'h03);
      wr(2'd1, 8'h07);
      expect_bytes(2, 8'h50, 1'b0, "R10 R4 iso sends DATA0");
      expect_beat(1'b1, 1'b0, 1'b0, 8'h00, "R10 iso close");
      pulse_in(); drain();
      rd(2'd2, v); chk("R10 iso done", v, 8'h01);

      // R10 unclaimed packet flushed at SOF
      frame_lsb = 1'b0;
      fill(2, 8'h60);
      wr(2'd1, 8'h03);
      repeat (3) @(negedge clk);
      @(negedge clk); sof_evt = 1'b1;
      @(negedge clk); sof_evt = 1'b0;
      repeat (2) @(negedge clk);
      rd(2'd1, v); chk("R10 sof clears enable and LAST", v, 8'h00);
      rd(2'd2, v); chk("R10 sof sets done", v, 8'h01);
      wr(2'd1, 8'h03);
      expect_beat(1'b1, 1'b0, 1'b0, 8'h00, "R10 fifo emptied at sof");
      pulse_in(); drain();
      rd(2'd2, v); chk("R10 done after empty packet", v, 8'h01);

      // R10 parity gate removed by bit 7
      frame_lsb = 1'b1;
      fill(1, 8'h70);
      wr(2'd1, 8'h83);
      expect_bytes(1, 8'h70, 1'b0, "R10 ignore parity");
      expect_beat(1'b1, 1'b0, 1'b0, 8'h00, "R10 ignore parity close");
      pulse_in(); drain();
      rd(2'd2, v); chk("R10 ignore parity done", v, 8'h01);
      iso_mode = 1'b0;

      chk("R3 scoreboard empty", exp_q.size(), 0);
      finish_run();
   end

endmodule